// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset this block fetches the switch's power-up configuration from an external two-wire serial EEPROM and writes each byte into the matching configuration register. It runs only when both the interface-enable strap and the auto-load strap are high. It drives the serial clock and pulls the data line low through an open-drain enable. The first byte read, at EEPROM address 0, gives the last address to fetch. The block then reads every address up to and including that one in a single sequential burst.

Each byte is routed by its address. The targets are the aging timer, one port-group mask per port, the packed uplink (flood target) nibbles, the broadcast, pause-on and pause-off thresholds, the disabled-port mask and the system control byte. Two static MAC entries are gathered byte by byte. Each entry is presented on an output with a one-cycle strobe, for the address table to insert. A missing acknowledge from the EEPROM ends the load early and leaves every register at its default. In all cases the block finishes by raising a done level that stays high until the next reset.

Top module: `cfgld_loader`

## Requirements
- R1: While reset is low and after its release until a byte is decoded, the registers hold their defaults: aging 0x012C, group mask of port p equal to 0xFF with bit p cleared, every uplink nibble 0xF, broadcast threshold 0xFF, pause-on 0x74, pause-off 0x30, disabled-port mask 0x00, enhanced back pressure 0; done is low, SCL is high and the data line is released.
- R2: If either strap is low when reset is released, no SCL edge occurs, done rises and every register keeps its default.
- R3: The bus sequence is: start, 0xA0 with ACK, word address 0x00, repeated start, 0xA1, then sequential reads. The master drives ACK (low) after every byte except the last, and NACK (released) followed by a stop after the last. The master changes the data line while SCL is high only to form a start or a stop. One SCL period lasts 4*QTR_CYC clock cycles.
- R4: The byte read at address 0 is the last address L; exactly L+1 bytes (addresses 0..L) are read, so with L=0 only address 0 is read.
- R5: Address 0x01 loads aging bits [7:0] and address 0x02 loads aging bits [15:8].
- R6: Address 0x03+p loads the group mask of port p, for p in 0..4.
- R7: Address 0x0B carries port 0 in bits [3:0] and port 1 in [7:4]. Address 0x0C carries port 2 in [3:0] and port 3 in [7:4]. Address 0x0D carries port 4 in [3:0]. A nibble of 0x0..0x7 or 0xF is stored as read; 0xF means flood to all other ports. A nibble of 0x8..0xE is stored as 0xF.
- R8: 0x0F loads the broadcast threshold, 0x10 pause-on, 0x11 pause-off, 0x12 the disabled-port mask, and bit 0 of 0x13 the enhanced back pressure enable.
- R9: Static entry 1 takes MAC bits [8k+7:8k] from address 0x20+k (k=0..5, so 0x25 is the most significant byte) and its port from bits [2:0] of 0x26. Its strobe is high for one cycle after 0x26 is read. Entry 2 uses 0x27..0x2C and 0x2D in the same way. No strobe occurs for an entry whose port byte lies beyond L.
- R10: If the EEPROM does not acknowledge a device or word address byte, the block sends a stop, raises done and keeps every register at its default.
- R11: Once high, done stays high until reset, and the bus stays idle (SCL high, data released).
- R12: Bytes at unmapped addresses (0x08..0x0A, 0x0E, 0x14..0x1F, above 0x2D) and bits [7:4] of 0x0D change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_en_i | input | 1 | Interface enable strap |
| autoload_i | input | 1 | Auto-load enable strap |
| scl_o | output | 1 | Serial clock to the EEPROM |
| sda_i | input | 1 | Sensed level of the data line |
| sda_oe_o | output | 1 | Pull the data line low when high |
| done_o | output | 1 | Load finished (sticky) |
| age_time_o | output | 16 | Aging time |
| vlan_mask_o | output | 8*NUM_PORTS | Per-port group masks, port p at [8p+7:8p] |
| uplink_o | output | 4*NUM_PORTS | Per-port flood target, port p at [4p+3:4p] |
| bcast_th_o | output | 8 | Broadcast threshold |
| xon_th_o | output | 8 | Pause-on threshold |
| xoff_th_o | output | 8 | Pause-off threshold |
| dis_port_o | output | 8 | Disabled-port mask |
| enh_bp_o | output | 1 | Enhanced back pressure enable |
| static_valid_o | output | 1 | One-cycle strobe for a static entry |
| static_mac_o | output | 48 | Static entry MAC address |
| static_port_o | output | 3 | Static entry port |

## Verification
The hardest situations to reach are the ends of the burst. One is the NACK decided on the very byte that defines the burst length (L=0). The others are a burst that stops in the middle of a static entry, and an EEPROM that never acknowledges. The bench models the EEPROM at the bit level. It acknowledges or ignores its device address, streams the image from its address pointer, and checks the master's ACK or NACK against L on every byte. Images are built with chosen last addresses (0, 0x05, 0x24, 0x26, 0x2D) and with illegal uplink nibbles, so that each ending and each substitution occurs.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WRITE, BC_READ} bus_cmd_e;

  localparam logic [7:0] A_AGE_LO   = 8'h01;
  localparam logic [7:0] A_AGE_HI   = 8'h02;
  localparam logic [7:0] A_VLAN     = 8'h03;
  localparam logic [7:0] A_UPLINK   = 8'h0B;
  localparam logic [7:0] A_BCAST    = 8'h0F;
  localparam logic [7:0] A_XON      = 8'h10;
  localparam logic [7:0] A_XOFF     = 8'h11;
  localparam logic [7:0] A_DISPORT  = 8'h12;
  localparam logic [7:0] A_SYSCTL   = 8'h13;
  localparam logic [7:0] A_STATIC1  = 8'h20;
  localparam logic [7:0] A_STATIC2  = 8'h27;
  localparam int         MAC_BYTES  = 6;

  localparam logic [15:0] DEF_AGE   = 16'd300;
  localparam logic [7:0]  DEF_BCAST = 8'hFF;
  localparam logic [7:0]  DEF_XON   = 8'h74;
  localparam logic [7:0]  DEF_XOFF  = 8'h30;

  function automatic logic [3:0] uplink_fix(logic [3:0] n);
    return (n[3] && n != 4'hF) ? 4'hF : n;
  endfunction
endpackage

// File: rtl/cfgld_bus.sv
module cfgld_bus
  import cfgld_pkg::*;
#(
  parameter int QTR_CYC = 625
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  bus_cmd_e   cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       nack_i,
  output logic       op_done_o,
  output logic [7:0] rdata_o,
  output logic       ack_ok_o,
  output logic       scl_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  localparam int QW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

  logic          active_q;
  bus_cmd_e      cmd_q;
  logic [QW-1:0] qcnt_q;
  logic [1:0]    phase_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q;
  logic          ack_q, done_q, scl_q, oe_q;
  logic          scl_d, oe_d;

  wire qend     = (qcnt_q == QW'(QTR_CYC - 1));
  wire single   = (cmd_q == BC_START) || (cmd_q == BC_STOP);
  wire last_bit = single || (bit_q == 4'd8);
  wire ack_slot = (bit_q == 4'd8);
  wire hi_phase = (phase_q == 2'd1) || (phase_q == 2'd2);

  always_comb begin
    scl_d = 1'b1;
    oe_d  = 1'b0;
    unique case (cmd_q)
      BC_START: begin scl_d = hi_phase; oe_d = phase_q[1]; end
      BC_STOP:  begin scl_d = (phase_q != 2'd0); oe_d = !phase_q[1]; end
      BC_WRITE: begin scl_d = hi_phase; oe_d = ack_slot ? 1'b0 : !sh_q[~bit_q[2:0]]; end
      BC_READ:  begin scl_d = hi_phase; oe_d = ack_slot ? !nack_i : 1'b0; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cmd_q    <= BC_STOP;
      qcnt_q   <= '0;
      phase_q  <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
      scl_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (cmd_valid_i) begin
          active_q <= 1'b1;
          cmd_q    <= cmd_i;
          sh_q     <= (cmd_i == BC_WRITE) ? wdata_i : 8'h00;
          qcnt_q   <= '0;
          phase_q  <= '0;
          bit_q    <= '0;
        end
      end else begin
        scl_q <= scl_d;   // held while idle so the bus keeps its level between commands
        oe_q  <= oe_d;
        if (qend) begin
          qcnt_q <= '0;
          if (phase_q == 2'd1 && !single) begin
            if (ack_slot)               ack_q <= !sda_i;
            else if (cmd_q == BC_READ)  sh_q  <= {sh_q[6:0], sda_i};
          end
          if (phase_q == 2'd3) begin
            phase_q <= '0;
            if (last_bit) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 4'd1;
            end
          end else begin
            phase_q <= phase_q + 2'd1;
          end
        end else begin
          qcnt_q <= qcnt_q + QW'(1);
        end
      end
    end
  end

  assign op_done_o = done_q;
  assign rdata_o   = sh_q;
  assign ack_ok_o  = ack_q;
  assign scl_o     = scl_q;
  assign sda_oe_o  = oe_q;

  // data only moves under a high clock to form start/stop
  assert_sda_under_scl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> (cmd_q == BC_START || cmd_q == BC_STOP));

  assert_no_cmd_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !$past(done_q)) |-> !cmd_valid_i);
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_en_i,
  output logic       cmd_valid_o,
  output bus_cmd_e   cmd_o,
  output logic [7:0] wdata_o,
  output logic       nack_o,
  input  logic       op_done_i,
  input  logic       ack_ok_i,
  input  logic [7:0] rdata_i,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       done_o
);
  typedef enum logic [3:0] {
    ST_BOOT, ST_START1, ST_DEVW, ST_WADDR, ST_START2, ST_DEVR, ST_READ, ST_STOP, ST_DONE
  } seq_state_e;

  seq_state_e state_q;
  logic       wait_q;
  logic [7:0] addr_q, last_q;
  logic       wr_en_q;
  logic [7:0] wr_addr_q, wr_data_q;

  wire on_bus = !(state_q inside {ST_BOOT, ST_DONE});

  always_comb begin
    cmd_o   = BC_STOP;
    wdata_o = 8'h00;
    unique case (state_q)
      ST_START1, ST_START2: cmd_o = BC_START;
      ST_DEVW:  begin cmd_o = BC_WRITE; wdata_o = {DEV_ADDR, 1'b0}; end
      ST_WADDR: begin cmd_o = BC_WRITE; wdata_o = 8'h00; end
      ST_DEVR:  begin cmd_o = BC_WRITE; wdata_o = {DEV_ADDR, 1'b1}; end
      ST_READ:  cmd_o = BC_READ;
      default:  ;
    endcase
  end

  assign cmd_valid_o = on_bus && !wait_q;
  // the byte at address 0 decides its own acknowledge
  assign nack_o = (addr_q == 8'h00) ? (rdata_i == 8'h00) : (addr_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BOOT;
      wait_q    <= 1'b0;
      addr_q    <= '0;
      last_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (cmd_valid_o) wait_q <= 1'b1;
      if (state_q == ST_BOOT) begin
        state_q <= start_en_i ? ST_START1 : ST_DONE;
      end else if (on_bus && wait_q && op_done_i) begin
        wait_q <= 1'b0;
        unique case (state_q)
          ST_START1: state_q <= ST_DEVW;
          ST_DEVW:   state_q <= ack_ok_i ? ST_WADDR  : ST_STOP;
          ST_WADDR:  state_q <= ack_ok_i ? ST_START2 : ST_STOP;
          ST_START2: state_q <= ST_DEVR;
          ST_DEVR:   state_q <= ack_ok_i ? ST_READ   : ST_STOP;
          ST_READ: begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= addr_q;
            wr_data_q <= rdata_i;
            if (addr_q == 8'h00) last_q <= rdata_i;
            if (nack_o) state_q <= ST_STOP;
            else        addr_q  <= addr_q + 8'd1;
          end
          ST_STOP:   state_q <= ST_DONE;
          default:   ;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign done_o    = (state_q == ST_DONE);

  assert_done_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_within_burst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o != 8'h00) |-> (wr_addr_o <= last_q));
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs
  import cfgld_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [7:0]             wr_addr_i,
  input  logic [7:0]             wr_data_i,
  output logic [15:0]            age_time_o,
  output logic [NUM_PORTS*8-1:0] vlan_mask_o,
  output logic [NUM_PORTS*4-1:0] uplink_o,
  output logic [7:0]             bcast_th_o,
  output logic [7:0]             xon_th_o,
  output logic [7:0]             xoff_th_o,
  output logic [7:0]             dis_port_o,
  output logic                   enh_bp_o,
  output logic                   static_valid_o,
  output logic [47:0]            static_mac_o,
  output logic [2:0]             static_port_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [7:0] VLAN_ADDR = A_VLAN + 8'(p);
    localparam logic [7:0] UPL_ADDR  = A_UPLINK + 8'(p / 2);
    localparam bit         UPL_HI    = (p % 2) == 1;
    localparam logic [7:0] VLAN_DEF  = ~(8'h01 << p);

    wire [3:0] nib = UPL_HI ? wr_data_i[7:4] : wr_data_i[3:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vlan_mask_o[p*8 +: 8] <= VLAN_DEF;
        uplink_o[p*4 +: 4]    <= 4'hF;
      end else if (wr_en_i) begin
        if (wr_addr_i == VLAN_ADDR) vlan_mask_o[p*8 +: 8] <= wr_data_i;
        if (wr_addr_i == UPL_ADDR)  uplink_o[p*4 +: 4]    <= uplink_fix(nib);
      end
    end

    assert_uplink_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!uplink_o[p*4+3] || uplink_o[p*4 +: 4] == 4'hF));
  end

  logic [47:0] stage_q;
  wire  [7:0]  off1 = wr_addr_i - A_STATIC1;
  wire  [7:0]  off2 = wr_addr_i - A_STATIC2;
  wire         in1  = off1 < 8'(MAC_BYTES);
  wire         in2  = off2 < 8'(MAC_BYTES);
  wire  [2:0]  idx  = in1 ? off1[2:0] : off2[2:0];
  wire         port_byte = (off1 == 8'(MAC_BYTES)) || (off2 == 8'(MAC_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_time_o     <= DEF_AGE;
      bcast_th_o     <= DEF_BCAST;
      xon_th_o       <= DEF_XON;
      xoff_th_o      <= DEF_XOFF;
      dis_port_o     <= 8'h00;
      enh_bp_o       <= 1'b0;
      stage_q        <= '0;
      static_valid_o <= 1'b0;
      static_mac_o   <= '0;
      static_port_o  <= '0;
    end else begin
      static_valid_o <= 1'b0;
      if (wr_en_i) begin
        unique case (wr_addr_i)
          A_AGE_LO:  age_time_o[7:0]  <= wr_data_i;
          A_AGE_HI:  age_time_o[15:8] <= wr_data_i;
          A_BCAST:   bcast_th_o       <= wr_data_i;
          A_XON:     xon_th_o         <= wr_data_i;
          A_XOFF:    xoff_th_o        <= wr_data_i;
          A_DISPORT: dis_port_o       <= wr_data_i;
          A_SYSCTL:  enh_bp_o         <= wr_data_i[0];
          default:   ;
        endcase
        if (in1 || in2) stage_q[idx*8 +: 8] <= wr_data_i;
        if (port_byte) begin
          static_mac_o   <= stage_q;
          static_port_o  <= wr_data_i[2:0];
          static_valid_o <= 1'b1;
        end
      end
    end
  end

  assert_static_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_valid_o |=> !static_valid_o);
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
  import cfgld_pkg::*;
#(
  parameter int         QTR_CYC   = 625,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         NUM_PORTS = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   if_en_i,
  input  logic                   autoload_i,
  output logic                   scl_o,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic                   done_o,
  output logic [15:0]            age_time_o,
  output logic [NUM_PORTS*8-1:0] vlan_mask_o,
  output logic [NUM_PORTS*4-1:0] uplink_o,
  output logic [7:0]             bcast_th_o,
  output logic [7:0]             xon_th_o,
  output logic [7:0]             xoff_th_o,
  output logic [7:0]             dis_port_o,
  output logic                   enh_bp_o,
  output logic                   static_valid_o,
  output logic [47:0]            static_mac_o,
  output logic [2:0]             static_port_o
);
  logic       cmd_valid, nack, op_done, ack_ok, wr_en;
  bus_cmd_e   cmd;
  logic [7:0] wdata, rdata, wr_addr, wr_data;

  cfgld_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk_i, .rst_ni,
    .start_en_i  (if_en_i & autoload_i),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd),
    .wdata_o     (wdata),
    .nack_o      (nack),
    .op_done_i   (op_done),
    .ack_ok_i    (ack_ok),
    .rdata_i     (rdata),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .done_o      (done_o)
  );

  cfgld_bus #(.QTR_CYC(QTR_CYC)) u_bus (
    .clk_i, .rst_ni,
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .wdata_i     (wdata),
    .nack_i      (nack),
    .op_done_o   (op_done),
    .rdata_o     (rdata),
    .ack_ok_o    (ack_ok),
    .scl_o       (scl_o),
    .sda_oe_o    (sda_oe_o),
    .sda_i       (sda_i)
  );

  cfgld_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i        (wr_en),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .age_time_o     (age_time_o),
    .vlan_mask_o    (vlan_mask_o),
    .uplink_o       (uplink_o),
    .bcast_th_o     (bcast_th_o),
    .xon_th_o       (xon_th_o),
    .xoff_th_o      (xoff_th_o),
    .dis_port_o     (dis_port_o),
    .enh_bp_o       (enh_bp_o),
    .static_valid_o (static_valid_o),
    .static_mac_o   (static_mac_o),
    .static_port_o  (static_port_o)
  );

  assert_idle_after_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> (scl_o && !sda_oe_o));

  assert_no_write_after_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) |-> !wr_en);
endmodule

// File: tb/cfgld_loader_test.sv
module cfgld_loader_test;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic if_en = 1'b1, autoload = 1'b1;
  logic scl, sda_oe, done, sv, enh;
  logic [15:0] age;
  logic [NP*8-1:0] vlan;
  logic [NP*4-1:0] upl;
  logic [7:0] bc, xon, xoff, dis;
  logic [47:0] smac;
  logic [2:0] sport;
  logic slv_pull = 1'b0;
  wire sda_line = !(sda_oe || slv_pull);

  always #2 clk = ~clk;

  cfgld_loader #(.QTR_CYC(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .if_en_i(if_en), .autoload_i(autoload),
    .scl_o(scl), .sda_i(sda_line), .sda_oe_o(sda_oe), .done_o(done),
    .age_time_o(age), .vlan_mask_o(vlan), .uplink_o(upl), .bcast_th_o(bc),
    .xon_th_o(xon), .xoff_th_o(xoff), .dis_port_o(dis), .enh_bp_o(enh),
    .static_valid_o(sv), .static_mac_o(smac), .static_port_o(sport)
  );

  int total = 0, bad = 0;
  logic [7:0] mem [256];
  bit present = 1'b1;
  bit cmp_en = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected register image, built from the requirements
  logic [15:0] e_age;
  logic [7:0]  e_vlan [NP];
  logic [3:0]  e_upl [NP];
  logic [7:0]  e_bc, e_xon, e_xoff, e_dis;
  logic        e_enh;
  logic [50:0] exp_q [$];
  int          e_bytes;

  function automatic logic [3:0] fix(logic [3:0] n);
    return (n >= 4'h8 && n <= 4'hE) ? 4'hF : n;
  endfunction

  task automatic calc_expect(bit run);
    e_age = 16'h012C; e_bc = 8'hFF; e_xon = 8'h74; e_xoff = 8'h30; e_dis = 8'h00; e_enh = 1'b0;
    for (int p = 0; p < NP; p++) begin
      e_vlan[p] = 8'hFF & ~(8'h01 << p);
      e_upl[p] = 4'hF;
    end
    exp_q.delete();
    e_bytes = 0;
    if (!run) return;
    e_bytes = int'(mem[0]) + 1;
    for (int a = 1; a <= int'(mem[0]); a++) begin
      case (a)
        1: e_age[7:0] = mem[a];
        2: e_age[15:8] = mem[a];
        3, 4, 5, 6, 7: e_vlan[a-3] = mem[a];
        'h0B: begin e_upl[0] = fix(mem[a][3:0]); e_upl[1] = fix(mem[a][7:4]); end
        'h0C: begin e_upl[2] = fix(mem[a][3:0]); e_upl[3] = fix(mem[a][7:4]); end
        'h0D: e_upl[4] = fix(mem[a][3:0]);
        'h0F: e_bc = mem[a];
        'h10: e_xon = mem[a];
        'h11: e_xoff = mem[a];
        'h12: e_dis = mem[a];
        'h13: e_enh = mem[a][0];
        'h26, 'h2D: exp_q.push_back({mem[a][2:0], mem[a-1], mem[a-2], mem[a-3],
                                     mem[a-4], mem[a-5], mem[a-6]});
        default: ;
      endcase
    end
  endtask

  task automatic cmp_regs(string tag);
    chk({"R5 aging ", tag}, 64'(age), 64'(e_age));
    for (int p = 0; p < NP; p++) begin
      chk({"R6 vlan ", tag}, 64'(vlan[p*8 +: 8]), 64'(e_vlan[p]));
      chk({"R7 uplink ", tag}, 64'(upl[p*4 +: 4]), 64'(e_upl[p]));
    end
    chk({"R8 bcast ", tag}, 64'(bc), 64'(e_bc));
    chk({"R8 xon ", tag}, 64'(xon), 64'(e_xon));
    chk({"R8 xoff ", tag}, 64'(xoff), 64'(e_xoff));
    chk({"R8 disport ", tag}, 64'(dis), 64'(e_dis));
    chk({"R8 enh_bp ", tag}, 64'(enh), 64'(e_enh));
  endtask

  // EEPROM slave model, evaluated away from the design's edge
  typedef enum int {S_IDLE, S_DEV, S_DACK, S_WA, S_WACK, S_TX, S_MACK, S_MACK2} slv_e;
  slv_e st = S_IDLE;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] shreg, txb, ptr;
  int bitc, txc, dev_cnt, bytes_read, rises;
  bit is_rd, mack;

  always @(negedge clk) begin
    logic cs, cd;
    if (!rst_ni) begin
      st = S_IDLE; slv_pull = 1'b0; prev_scl = 1'b1; prev_sda = 1'b1;
    end else begin
      cs = scl; cd = sda_line;
      if (prev_scl && cs && prev_sda && !cd) begin
        st = S_DEV; bitc = 0; shreg = 8'h00; slv_pull = 1'b0;
      end else if (prev_scl && cs && !prev_sda && cd) begin
        st = S_IDLE; slv_pull = 1'b0;
      end else if (!prev_scl && cs) begin
        rises++;
        case (st)
          S_DEV, S_WA: begin shreg = {shreg[6:0], cd}; bitc++; end
          S_TX: txc++;
          S_MACK: begin
            mack = !cd;
            bytes_read++;
            chk("R3 master ack/nack after byte", 64'(mack), 64'(ptr != mem[0]));
            st = S_MACK2;
          end
          default: ;
        endcase
      end else if (prev_scl && !cs) begin
        case (st)
          S_DEV: if (bitc == 8) begin
            chk("R3 device byte", 64'(shreg), (dev_cnt == 0) ? 64'hA0 : 64'hA1);
            dev_cnt++;
            if (present && shreg[7:1] == 7'h50) begin
              slv_pull = 1'b1; is_rd = shreg[0]; st = S_DACK;
            end else st = S_IDLE;
          end
          S_WA: if (bitc == 8) begin
            chk("R3 word address", 64'(shreg), 64'h00);
            ptr = shreg; slv_pull = 1'b1; st = S_WACK;
          end
          S_DACK: begin
            if (is_rd) begin
              st = S_TX; txc = 0; txb = mem[ptr]; slv_pull = !txb[7];
            end else begin
              slv_pull = 1'b0; st = S_WA; bitc = 0; shreg = 8'h00;
            end
          end
          S_WACK: begin slv_pull = 1'b0; st = S_IDLE; end
          S_TX: begin
            if (txc < 8) slv_pull = !txb[7-txc];
            else begin slv_pull = 1'b0; st = S_MACK; end
          end
          S_MACK2: begin
            if (mack) begin
              ptr = ptr + 8'd1; txb = mem[ptr]; txc = 0; slv_pull = !txb[7]; st = S_TX;
            end else begin
              slv_pull = 1'b0; st = S_IDLE;
            end
          end
          default: ;
        endcase
      end
      prev_scl = cs; prev_sda = cd;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_ni && cmp_en) begin
      if (sv) begin
        if (exp_q.size() == 0) chk("R9 unexpected static strobe", 64'(1), 64'(0));
        else begin
          logic [50:0] e;
          e = exp_q.pop_front();
          chk("R9 static entry", {13'h0, sport, smac}, {13'h0, e});
        end
      end
      if (done) begin
        cmp_regs("after done");
        chk("R11 bus idle after done", {62'h0, scl, sda_oe}, 64'h2);
      end
    end
  end

  task automatic fill_image(int last);
    for (int a = 0; a < 256; a++) mem[a] = 8'(8'h77 ^ a);
    mem[0] = 8'(last);
    mem[1] = 8'h13; mem[2] = 8'h2C;
    mem[3] = 8'h1E; mem[4] = 8'hC3; mem[5] = 8'h5A; mem[6] = 8'h81; mem[7] = 8'h0F;
    mem[8] = 8'h55; mem[9] = 8'hAA; mem['h0A] = 8'h01;          // unmapped, R12
    mem['h0B] = 8'h93;                                          // port1 illegal 9, port0 3
    mem['h0C] = 8'hE7;                                          // port3 illegal E, port2 7
    mem['h0D] = 8'hA2;                                          // upper nibble unused
    mem['h0E] = 8'h44;
    mem['h0F] = 8'h40; mem['h10] = 8'h2E; mem['h11] = 8'h18; mem['h12] = 8'h06; mem['h13] = 8'hFF;
    for (int k = 0; k < 6; k++) begin
      mem['h20 + k] = 8'(8'h11 * (k + 1));
      mem['h27 + k] = 8'(8'hA0 + k);
    end
    mem['h26] = 8'hFD; mem['h2D] = 8'h02;
  endtask

  task automatic run_case(string name, bit ife, bit al, bit pres);
    int wd;
    bit run;
    rst_ni = 1'b0; cmp_en = 1'b0;
    if_en = ife; autoload = al; present = pres;
    bytes_read = 0; rises = 0; dev_cnt = 0;
    calc_expect(1'b0);
    repeat (3) @(negedge clk);
    cmp_regs({"R1 reset ", name});
    chk({"R1 reset done/scl/oe ", name}, {61'h0, done, scl, sda_oe}, 64'h2);
    run = ife && al;
    calc_expect(run && pres);
    if (run && !pres) e_bytes = 0;
    cmp_en = 1'b1;
    rst_ni = 1'b1;
    @(negedge clk);
    chk({"R1 defaults held after release ", name}, 64'(age), 64'h012C);
    wd = 0;
    while (!done && wd < 40000) begin @(negedge clk); wd++; end
    if (!done) chk({"R11 watchdog waiting for done ", name}, 64'(0), 64'(1));
    repeat (25) @(negedge clk);
    chk({"R11 done held ", name}, 64'(done), 64'(1));
    chk({"R4 bytes read ", name}, 64'(bytes_read), 64'(e_bytes));
    chk({"R9 all static entries seen ", name}, 64'(exp_q.size()), 64'(0));
    if (!run) chk({"R2 no clock edges with strap low ", name}, 64'(rises), 64'(0));
    cmp_en = 1'b0;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL R11 watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // full map: aging, masks, uplinks with illegal nibbles, thresholds, both static entries
    fill_image('h2D);
    run_case("full", 1'b1, 1'b1, 1'b1);
    chk("R7 illegal nibble 9 becomes F", 64'(upl[7:4]), 64'hF);
    chk("R7 illegal nibble E becomes F", 64'(upl[15:12]), 64'hF);
    chk("R12 upper nibble of port4 byte ignored", 64'(upl[19:16]), 64'h2);
    chk("R9 second entry last seen", {13'h0, sport, smac}, {13'h0, 3'd2, 48'hA5A4A3A2A1A0});
    // short burst ending inside the masks
    fill_image('h05);
    run_case("last 0x05", 1'b1, 1'b1, 1'b1);
    chk("R6 mask of port 3 untouched", 64'(vlan[31:24]), 64'hF7);
    // burst ends in the middle of static entry 1: no strobe
    fill_image('h24);
    run_case("last 0x24", 1'b1, 1'b1, 1'b1);
    // burst ends on the first port byte
    fill_image('h26);
    run_case("last 0x26", 1'b1, 1'b1, 1'b1);
    // length byte zero: NACK on the very first byte
    fill_image(0);
    run_case("last 0x00", 1'b1, 1'b1, 1'b1);
    // EEPROM absent: no acknowledge on the device byte
    fill_image('h2D);
    run_case("absent R10", 1'b1, 1'b1, 1'b0);
    chk("R10 defaults after missing ack", 64'(xon), 64'h74);
    // straps low
    run_case("if_en low", 1'b0, 1'b1, 1'b1);
    run_case("autoload low", 1'b1, 1'b0, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule